// File: doc/BRIEF.md
# Card Host Status and Interrupt Unit

This unit holds the event status of a memory-card host controller and turns it into two interrupt lines. The command and data engines give it one-cycle event pulses. Each pulse sets a bit that stays set until software clears it by writing ones to the clear register. The transmit, receive and command activity flags and the FIFO fill-level flags come in as live levels. The unit does not store them. They sit in the upper part of the status word, and clearing has no effect on them.

Software programs two independent mask registers. Each interrupt line is a level that is high while any unmasked status bit is set, so one line can serve the processor and the other a DMA or secondary agent. The unit also holds the 8-bit power and clock control registers. It exposes a fixed eight-byte identification window at the top of the 4 KiB register page.

Register offsets used by this unit:
- 0x000: power
- 0x004: clock
- 0x010: status, read only
- 0x014: clear, write only
- 0x018: mask for `irq0`
- 0x01C: mask for `irq1`
- 0xFE0 to 0xFFF: identification window

All other offsets read zero.

Top module: `csh_status_irq`

## Requirements
- R1: After reset, the status event bits, both masks, power and clock all read 0, and `irq0` and `irq1` are low.
- R2: A pulse on `evtIn[i]` (for i in 0..8 or 10) sets status bit i from the next cycle on. The bit stays set with no further pulses.
- R3: A write to the clear register (0x014) clears each status bit 10:0 whose written data bit is 1. Bits written as 0 stay unchanged.
- R4: Status bits 21:11 show `liveIn[10:0]` in the same cycle, and a clear write cannot change them.
- R5: When an event pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R6: `irq0` is high exactly when (status AND mask0) is nonzero. `irq1` is high exactly when (status AND mask1) is nonzero. The two lines are independent. A mask write or a live-flag change shows on the line in the cycle the register or input changes.
- R7: Reading 0xFE0 + 4k for k = 0..7 returns, in order, 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, zero-extended.
- R8: The power (0x000) and clock (0x004) registers keep only bits 7:0 of a write, and the upper read bits are 0.
- R9: `evtIn[9]` has no effect, and status bit 9 always reads 0.
- R10: A read of an unmapped offset, including the clear register, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte offset for read and write |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data for `regAddr`, combinational |
| evtIn | input | 11 | Event pulses for status bits 10:0 |
| liveIn | input | 11 | Live flags shown as status bits 21:11 |
| irq0 | output | 1 | Interrupt level gated by mask0 |
| irq1 | output | 1 | Interrupt level gated by mask1 |

## Verification
A register write or an event pulse is captured at one rising edge. The new value is due on `regRdata` and on the interrupt lines right after that edge, because both are combinational from the registers. Live-flag changes and read-address changes are due in the same cycle, with no edge needed.

The bench drives every input just after a falling edge and lets a single rising edge pass. It then reads, one time step after the following falling edge, so each check samples exactly the cycle in which its result is due.

// File: rtl/csh_pkg.sv
package csh_pkg;
  localparam int EVT_W  = 11;
  localparam int LIVE_W = 11;
  localparam int STAT_W = EVT_W + LIVE_W;
  localparam int ID_N   = 8;
  localparam logic [EVT_W-1:0] EVT_USED = 11'b101_1111_1111;

  localparam logic [11:0] OFS_POWER  = 12'h000;
  localparam logic [11:0] OFS_CLOCK  = 12'h004;
  localparam logic [11:0] OFS_STATUS = 12'h010;
  localparam logic [11:0] OFS_CLEAR  = 12'h014;
  localparam logic [11:0] OFS_MASK0  = 12'h018;
  localparam logic [11:0] OFS_MASK1  = 12'h01C;
  localparam logic [11:0] OFS_IDBASE = 12'hFE0;

  typedef struct packed {
    logic wrPower;
    logic wrClock;
    logic wrClear;
    logic wrMask0;
    logic wrMask1;
  } strobeT;

  typedef enum logic [2:0] {
    RD_NONE, RD_POWER, RD_CLOCK, RD_STATUS, RD_MASK0, RD_MASK1, RD_ID
  } rdSelT;

  function automatic logic [7:0] idByte(input logic [2:0] idx);
    case (idx)
      3'd0: idByte = 8'h81;
      3'd1: idByte = 8'h11;
      3'd2: idByte = 8'h04;
      3'd3: idByte = 8'h00;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/csh_ctrl.sv
module csh_ctrl
  import csh_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobeT            strb,
  output rdSelT             rdSel,
  output logic [2:0]        idIdx
);
  logic [11:0] ofs;
  logic        idHit;

  always_comb begin
    ofs = 12'(regAddr);
    idHit = (ofs >= OFS_IDBASE);
    idIdx = 3'((ofs - OFS_IDBASE) >> 2);
  end

  always_comb begin
    strb = '0;
    if (regWrEn) begin
      strb.wrPower = (ofs == OFS_POWER);
      strb.wrClock = (ofs == OFS_CLOCK);
      strb.wrClear = (ofs == OFS_CLEAR);
      strb.wrMask0 = (ofs == OFS_MASK0);
      strb.wrMask1 = (ofs == OFS_MASK1);
    end
  end

  always_comb begin
    if (idHit)                  rdSel = RD_ID;
    else if (ofs == OFS_POWER)  rdSel = RD_POWER;
    else if (ofs == OFS_CLOCK)  rdSel = RD_CLOCK;
    else if (ofs == OFS_STATUS) rdSel = RD_STATUS;
    else if (ofs == OFS_MASK0)  rdSel = RD_MASK0;
    else if (ofs == OFS_MASK1)  rdSel = RD_MASK1;
    else                        rdSel = RD_NONE;
  end

  // R8 / R3: at most one register is written per cycle
  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));
  // R10: no write strobe without a write request
  assert_no_stray_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> (strb == '0));
endmodule

// File: rtl/csh_dpath.sv
module csh_dpath
  import csh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  rdSelT             rdSel,
  input  logic [2:0]        idIdx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [EVT_W-1:0]  evtIn,
  input  logic [LIVE_W-1:0] liveIn,
  output logic [DATA_W-1:0] rdata,
  output logic              irq0,
  output logic              irq1
);
  logic [EVT_W-1:0]  evtReg, evtSet, evtClr;
  logic [STAT_W-1:0] mask0Reg, mask1Reg, status;
  logic [CTRL_W-1:0] powerReg, clockReg;

  always_comb begin
    evtSet = evtIn & EVT_USED;
    evtClr = strb.wrClear ? wdata[EVT_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtReg   <= '0;
      mask0Reg <= '0;
      mask1Reg <= '0;
      powerReg <= '0;
      clockReg <= '0;
    end else begin
      evtReg <= (evtReg & ~evtClr) | evtSet;
      if (strb.wrMask0) mask0Reg <= wdata[STAT_W-1:0];
      if (strb.wrMask1) mask1Reg <= wdata[STAT_W-1:0];
      if (strb.wrPower) powerReg <= wdata[CTRL_W-1:0];
      if (strb.wrClock) clockReg <= wdata[CTRL_W-1:0];
    end
  end

  always_comb begin
    status = {liveIn, evtReg};
    irq0   = |(status & mask0Reg);
    irq1   = |(status & mask1Reg);
  end

  always_comb begin
    case (rdSel)
      RD_POWER:  rdata = DATA_W'(powerReg);
      RD_CLOCK:  rdata = DATA_W'(clockReg);
      RD_STATUS: rdata = DATA_W'(status);
      RD_MASK0:  rdata = DATA_W'(mask0Reg);
      RD_MASK1:  rdata = DATA_W'(mask1Reg);
      RD_ID:     rdata = DATA_W'(idByte(idIdx));
      default:   rdata = '0;
    endcase
  end

  // R1: reset empties event status and both masks
  assert_reset_clean_R1: assert property (@(posedge clk)
    !rstN |=> (evtReg == '0 && mask0Reg == '0 && mask1Reg == '0));
  // R2: without a clear write, set bits stay set
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrClear |=> ((evtReg & $past(evtReg)) == $past(evtReg)));
  // R3: a clear with no coinciding events drops every selected bit
  assert_clear_works_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrClear && evtIn == '0) |=> ((evtReg & $past(wdata[EVT_W-1:0])) == '0));
  // R5: an event always lands, even under a clear
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((evtReg & $past(evtSet)) == $past(evtSet)));
  // R6: an empty mask keeps its line low
  assert_mask_gates_R6: assert property (@(posedge clk) disable iff (!rstN)
    (mask0Reg == '0) |-> !irq0);
  // R9: the reserved event slot never sets
  assert_bit9_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    evtIn[9] |=> !evtReg[9]);
endmodule

// File: rtl/csh_status_irq.sv
module csh_status_irq
  import csh_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [EVT_W-1:0]  evtIn,
  input  logic [LIVE_W-1:0] liveIn,
  output logic              irq0,
  output logic              irq1
);
  strobeT     strb;
  rdSelT      rdSel;
  logic [2:0] idIdx;

  csh_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .strb(strb), .rdSel(rdSel), .idIdx(idIdx)
  );

  csh_dpath #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel), .idIdx(idIdx),
    .wdata(regWdata), .evtIn(evtIn), .liveIn(liveIn),
    .rdata(regRdata), .irq0(irq0), .irq1(irq1)
  );
endmodule

// File: tb/sim_csh_status_irq.sv
module sim_csh_status_irq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [10:0] evtIn = '0;
  logic [10:0] liveIn = '0;
  logic        irq0, irq1;
  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  csh_status_irq u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .evtIn(evtIn),
    .liveIn(liveIn), .irq0(irq0), .irq1(irq1)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one edge with the given write and event stimulus, then settle
  task automatic cycle(input bit we, input logic [11:0] a, input logic [31:0] d,
                       input logic [10:0] ev);
    @(negedge clk);
    regWrEn = we; regAddr = a; regWdata = d; evtIn = ev;
    @(negedge clk);
    regWrEn = 1'b0; evtIn = '0;
    #1;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    regAddr = a; #1; v = regRdata;
  endtask

  task automatic test_reset();
    logic [31:0] v;
    rd(12'h010, v); check("R1 status", v, 0);
    rd(12'h018, v); check("R1 mask0", v, 0);
    rd(12'h01C, v); check("R1 mask1", v, 0);
    rd(12'h000, v); check("R1 power", v, 0);
    rd(12'h004, v); check("R1 clock", v, 0);
    check("R1 irqs", {30'd0, irq1, irq0}, 0);
  endtask

  task automatic test_ctrl_regs();
    logic [31:0] v;
    cycle(1, 12'h000, 32'hABCD1234, 0);
    cycle(1, 12'h004, 32'hFFFFFF5A, 0);
    rd(12'h000, v); check("R8 power", v, 32'h34);
    rd(12'h004, v); check("R8 clock", v, 32'h5A);
  endtask

  task automatic test_sticky();
    logic [31:0] v;
    cycle(0, 12'h010, 0, 11'h401);
    rd(12'h010, v); check("R2 set", v, 32'h401);
    cycle(0, 12'h010, 0, 0);
    cycle(0, 12'h010, 0, 0);
    rd(12'h010, v); check("R2 hold", v, 32'h401);
    cycle(0, 12'h010, 0, 11'h200);
    rd(12'h010, v); check("R9 bit9", v, 32'h401);
  endtask

  task automatic test_clear();
    logic [31:0] v;
    cycle(1, 12'h014, 32'h1, 0);
    rd(12'h010, v); check("R3 partial", v, 32'h400);
    liveIn = 11'h5A5; #1;
    rd(12'h010, v); check("R4 live", v, {21'd0, 11'h400} | (32'h5A5 << 11));
    cycle(1, 12'h014, 32'hFFFFFFFF, 0);
    rd(12'h010, v); check("R4 clear keeps live", v, 32'h5A5 << 11);
    rd(12'h014, v); check("R10 clear reads 0", v, 0);
    liveIn = '0;
  endtask

  task automatic test_race();
    logic [31:0] v;
    cycle(1, 12'h014, 32'h8, 11'h008);
    rd(12'h010, v); check("R5 set wins", v, 32'h8);
  endtask

  task automatic test_irq();
    cycle(1, 12'h018, 32'h8, 0);
    check("R6 irq0 on", {30'd0, irq1, irq0}, 32'b01);
    cycle(1, 12'h01C, 32'h1000, 0);
    check("R6 irq1 off", {30'd0, irq1, irq0}, 32'b01);
    @(negedge clk); liveIn = 11'h002; #1;
    check("R6 irq1 live", {30'd0, irq1, irq0}, 32'b11);
    liveIn = '0; #1;
    check("R6 irq1 drop", {30'd0, irq1, irq0}, 32'b01);
    cycle(1, 12'h014, 32'h8, 0);
    check("R6 irq0 cleared", {30'd0, irq1, irq0}, 32'b00);
  endtask

  task automatic test_id();
    logic [31:0] v;
    logic [7:0] tbl [8] = '{8'h81, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int k = 0; k < 8; k++) begin
      rd(12'hFE0 + 12'(4 * k), v);
      check("R7 id", v, {24'd0, tbl[k]});
    end
    rd(12'h100, v); check("R10 unmapped", v, 0);
  endtask

  task automatic test_rereset();
    cycle(1, 12'h018, 32'h3FFFFF, 11'h001);
    check("R6 pre", {31'd0, irq0}, 1);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1; #1;
    test_reset();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1; #1;
    test_reset();
    test_ctrl_regs();
    test_sticky();
    test_clear();
    test_race();
    test_irq();
    test_id();
    test_rereset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule